// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block turns the status signals of a 10/100 Ethernet PHY into four indicator outputs: activity, link, 100 Mb/s speed and full duplex. Each indicator may need to be active-high or active-low, depending on how the board wires its LED. The board chooses this with the PHY address strap pins. The block captures those pins once, as it leaves reset, and uses one captured bit per indicator to set that indicator's drive polarity.

Carrier sense is usually only a short burst per frame, so the activity indicator is stretched. It stays lit for a programmable hold time after carrier sense drops. By default the hold time is 128 ms, derived from the clock rate in kHz and a time in ms. If carrier sense returns during the hold, the hold time is reloaded.

The link, speed and duplex indicators are combinational functions of the PHY status inputs. The speed indicator also lights while auto-negotiation runs, and it goes dark while the line is isolated. All indicators sit at their inactive level while reset is asserted.

Top module: `phy_led_drv`

## Requirements
- R1: Output index 0 is activity, 1 is link, 2 is 100 Mb/s speed and 3 is full duplex. When captured strap bit i is 1, `led_o[i]` is driven low when active and high when inactive. When the bit is 0, the output is driven high when active and low when inactive.
- R2: The strap bits are captured on the first rising clock edge after `rst_n` goes high. Later changes on `strap_i` have no effect on any output until the next reset.
- R3: From the assertion of `rst_n` low until the first rising edge after its release, every output sits at its inactive level, taken from the live `strap_i` pins. This holds regardless of the other inputs.
- R4: While `crs_i` is high, the activity output is active in the same cycle.
- R5: After `crs_i` falls, the activity output stays active for exactly `CLK_KHZ*HOLD_MS` rising clock edges. It becomes inactive on the last of those edges.
- R6: If `crs_i` rises again during the hold, the hold restarts. The full hold time is then counted from the most recent fall of `crs_i`.
- R7: The link output is active when `link100_i` is high while `spd100_i` is 1, or when `link10_i` is high while `spd100_i` is 0.
- R8: The speed output is active when `spd100_i` or `aneg_busy_i` is high, unless `isolate_i` is high. `isolate_i` forces the speed output inactive.
- R9: The full-duplex output is active exactly when `fdx_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Address strap pins that select the polarity of each indicator |
| crs_i | input | 1 | Carrier sense |
| link10_i | input | 1 | 10 Mb/s link valid |
| link100_i | input | 1 | 100 Mb/s link valid |
| spd100_i | input | 1 | Resolved speed, 1 = 100 Mb/s |
| aneg_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | Line isolate |
| fdx_i | input | 1 | Full-duplex mode |
| led_o | output | 4 | Indicator outputs {duplex, speed, link, activity} |

## Verification
The bench measures the activity hold to the exact edge, both after a single drop and after a carrier pulse inside the hold. An off-by-one counter or a missing reload would show up as an output that goes dark one edge early or late, or too soon after the retrigger.

It also moves the strap pins after reset, so a design that keeps sampling them would flip polarities while running. It asserts carrier sense while in reset, so a design that does not gate the outputs during reset would light the activity output early.

The bench sweeps every combination of speed, auto-negotiation and isolate. A design with the wrong priority would light the speed output during isolate or at 10 Mb/s.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
   localparam int NUM_LEDS = 4;
   typedef enum int {
      IDX_ACT  = 0,
      IDX_LINK = 1,
      IDX_SPD  = 2,
      IDX_FDX  = 3
   } led_idx_e;
endpackage

// File: rtl/phy_led_strap.sv
module phy_led_strap #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strap_i,
   output logic [N-1:0] pol_o,
   output logic         run_o
);
   logic [N-1:0] strap_q;
   logic         run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= '0;
         run_q   <= 1'b0;
      end else if (!run_q) begin
         strap_q <= strap_i;
         run_q   <= 1'b1;
      end
   end

   assign pol_o = run_q ? strap_q : strap_i;
   assign run_o = run_q;
endmodule

// File: rtl/phy_led_stretch.sv
module phy_led_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic crs_i,
   output logic act_o
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (crs_i)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign act_o = crs_i || (cnt_q != '0);
endmodule

// File: rtl/phy_led_pol.sv
module phy_led_pol #(
   parameter int N = 4
) (
   input  logic [N-1:0] on_i,
   input  logic [N-1:0] pol_i,
   output logic [N-1:0] led_o
);
   for (genvar g = 0; g < N; g++) begin : g_led
      assign led_o[g] = pol_i[g] ? ~on_i[g] : on_i[g];
   end
endmodule

// File: rtl/phy_led_drv.sv
module phy_led_drv
   import phy_led_pkg::*;
#(
   parameter int CLK_KHZ = 25000,
   parameter int HOLD_MS = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEDS-1:0] strap_i,
   input  logic                crs_i,
   input  logic                link10_i,
   input  logic                link100_i,
   input  logic                spd100_i,
   input  logic                aneg_busy_i,
   input  logic                isolate_i,
   input  logic                fdx_i,
   output logic [NUM_LEDS-1:0] led_o
);
   localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;

   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be at least 1");
   end
   if (HOLD_MS < 1) begin : g_bad_hold
      $error("HOLD_MS must be at least 1");
   end

   logic [NUM_LEDS-1:0] pol;
   logic [NUM_LEDS-1:0] on_raw;
   logic [NUM_LEDS-1:0] on_vec;
   logic                run;
   logic                act;

   phy_led_strap #(.N(NUM_LEDS)) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .pol_o   (pol),
      .run_o   (run)
   );

   phy_led_stretch #(.HOLD(HOLD_CYC)) u_str (
      .clk   (clk),
      .rst_n (rst_n),
      .crs_i (crs_i),
      .act_o (act)
   );

   always_comb begin
      on_raw           = '0;
      on_raw[IDX_ACT]  = act;
      on_raw[IDX_LINK] = spd100_i ? link100_i : link10_i;
      on_raw[IDX_SPD]  = !isolate_i && (spd100_i || aneg_busy_i);
      on_raw[IDX_FDX]  = fdx_i;
      on_vec           = on_raw & {NUM_LEDS{run}};
   end

   phy_led_pol #(.N(NUM_LEDS)) u_pol (
      .on_i  (on_vec),
      .pol_i (pol),
      .led_o (led_o)
   );
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk #(
   parameter int HOLD = 16,
   parameter int CW   = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          crs,
   input logic          iso,
   input logic          aneg,
   input logic          fdx,
   input logic [3:0]    pol,
   input logic [3:0]    led,
   input logic [CW-1:0] cnt
);
   // R4
   act_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && crs |-> led[0] != pol[0]);
   // R5
   stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && $fell(crs) |-> led[0] != pol[0]);
   // R5
   quiet_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !crs && $past(led[0] == pol[0]) |-> led[0] == pol[0]);
   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= HOLD);
   // R2
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) |-> $stable(pol));
   // R8
   iso_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && iso |-> led[2] == pol[2]);
   // R8
   aneg_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && aneg && !iso |-> led[2] != pol[2]);
   // R9
   fdx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (led[3] != pol[3]) == fdx);
endmodule

bind phy_led_drv phy_led_chk #(
   .HOLD (HOLD_CYC),
   .CW   ($clog2(HOLD_CYC + 1))
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .run  (run),
   .crs  (crs_i),
   .iso  (isolate_i),
   .aneg (aneg_busy_i),
   .fdx  (fdx_i),
   .pol  (pol),
   .led  (led_o),
   .cnt  (u_str.cnt_q)
);

// File: tb/phy_led_drv_tb.sv
module phy_led_drv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] strap_i = 4'b0000;
   logic       crs_i = 1'b0, link10_i = 1'b0, link100_i = 1'b0;
   logic       spd100_i = 1'b0, aneg_busy_i = 1'b0, isolate_i = 1'b0, fdx_i = 1'b0;
   logic [3:0] led_o;

   int         nchk = 0;
   int         nfail = 0;
   logic [3:0] pol_m = 4'b0000;
   bit         done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   phy_led_drv #(.CLK_KHZ(1), .HOLD_MS(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .crs_i(crs_i),
      .link10_i(link10_i), .link100_i(link100_i), .spd100_i(spd100_i),
      .aneg_busy_i(aneg_busy_i), .isolate_i(isolate_i), .fdx_i(fdx_i),
      .led_o(led_o)
   );

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: led_o=%b expected %b", req, got, exp);
      end
   endtask

   function automatic logic [3:0] want(input logic [3:0] on);
      return on ^ pol_m;
   endfunction

   task automatic idle_inputs();
      crs_i = 0; link10_i = 0; link100_i = 0; spd100_i = 0;
      aneg_busy_i = 0; isolate_i = 0; fdx_i = 0;
   endtask

   // R3 checked in reset, R1 after release
   task automatic do_reset(input logic [3:0] strap);
      @(negedge clk);
      rst_n = 0; strap_i = strap; idle_inputs(); crs_i = 1; fdx_i = 1;
      #1 chk("R3 in reset", led_o, strap);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R3 in reset after edges", led_o, strap);
      idle_inputs();
      rst_n = 1;
      #1 chk("R3 released before edge", led_o, strap);
      @(posedge clk);
      pol_m = strap;
      @(negedge clk);
      #1 chk("R1 idle after capture", led_o, want(4'b0000));
   endtask

   task automatic t_link();
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         spd100_i = v[2]; link100_i = v[1]; link10_i = v[0];
         #1 chk("R7 link select", led_o,
                want({1'b0, v[2] && !isolate_i, v[2] ? v[1] : v[0], 1'b0}));
      end
      @(negedge clk); idle_inputs();
   endtask

   task automatic t_speed();
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         spd100_i = v[2]; aneg_busy_i = v[1]; isolate_i = v[0];
         #1 chk("R8 speed", led_o,
                want({1'b0, !v[0] && (v[2] || v[1]), 1'b0, 1'b0}));
      end
      @(negedge clk); idle_inputs();
   endtask

   task automatic t_fdx();
      @(negedge clk); fdx_i = 1;
      #1 chk("R9 fdx on", led_o, want(4'b1000));
      @(negedge clk); fdx_i = 0;
      #1 chk("R9 fdx off", led_o, want(4'b0000));
   endtask

   task automatic t_act_stretch();
      @(negedge clk); crs_i = 1;
      #1 chk("R4 act with crs", led_o, want(4'b0001));
      repeat (3) @(posedge clk);
      @(negedge clk); crs_i = 0;
      #1 chk("R5 act right after drop", led_o, want(4'b0001));
      for (int k = 1; k <= HOLD; k++) begin
         @(negedge clk);
         #1;
         if (k == HOLD - 1) chk("R5 act last held edge", led_o, want(4'b0001));
         if (k == HOLD)     chk("R5 act off after hold", led_o, want(4'b0000));
      end
   endtask

   task automatic t_act_retrigger();
      @(negedge clk); crs_i = 1;
      @(negedge clk); crs_i = 0;
      repeat (5) @(negedge clk);
      crs_i = 1;
      @(negedge clk); crs_i = 0;
      for (int k = 1; k <= HOLD; k++) begin
         @(negedge clk);
         #1;
         if (k == HOLD - 1) chk("R6 retrigger still held", led_o, want(4'b0001));
         if (k == HOLD)     chk("R6 retrigger off", led_o, want(4'b0000));
      end
   endtask

   task automatic t_strap_hold();
      @(negedge clk); strap_i = ~pol_m;
      repeat (3) @(negedge clk);
      #1 chk("R2 strap change ignored idle", led_o, want(4'b0000));
      fdx_i = 1;
      #1 chk("R2 strap change ignored active", led_o, want(4'b1000));
      @(negedge clk); fdx_i = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      do_reset(4'b1010);
      t_link(); t_speed(); t_fdx(); t_act_stretch(); t_act_retrigger();
      t_strap_hold();
      do_reset(4'b0101);
      t_link(); t_speed(); t_fdx(); t_act_stretch();
      t_strap_hold();
      do_reset(4'b0000);
      t_fdx(); t_act_retrigger();
      finish_run();
   end
endmodule